// File: doc/BRIEF.md
# Element-Width-Scaled Sign Extender

This unit treats a 64-bit operand as a row of packed lanes whose width is chosen per operation: 64, 32, 16 or 8 bits. Three extension opcodes, called byte, half and word, each take a field from the low end of every lane and copy that field's top bit up through the rest of the lane. The field is not a fixed number of bits. It is one eighth of the lane width for the byte opcode, one quarter for the half opcode and one half for the word opcode. A fourth opcode copies the operand through unchanged.

With 64-bit lanes the opcodes behave like ordinary 8/16/32-bit sign extension. With narrower lanes they give cheap mask building. The byte opcode on 8-bit lanes turns bit 0 of each byte into 0x00 or 0xFF. The half opcode on 32-bit lanes widens the low byte of each word to the full word. The result and its valid strobe are registered, so the latency is one cycle.

Top module: `elw_sext_unit`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, valid_o is 0.
- R2: valid_o equals valid_i delayed by one clock. The result_o that goes with it is computed from the operand_i, ew_i and op_i sampled at that same edge.
- R3: op_i = 2'b00 (byte) sign-extends the low lane_width/8 bits of every lane to the full lane.
- R4: op_i = 2'b01 (half) sign-extends the low lane_width/4 bits of every lane. With 32-bit lanes this widens the low byte of each word to 32 bits.
- R5: op_i = 2'b10 (word) sign-extends the low lane_width/2 bits of every lane. With 64-bit lanes this is a 32-to-64-bit extension.
- R6: ew_i selects the lane width: 2'b00 = 64, 2'b01 = 32, 2'b10 = 16, 2'b11 = 8. Lane k occupies bits [k*w + w-1 : k*w].
- R7: op_i = 2'b11 copies operand_i to result_o unchanged, whatever ew_i is.
- R8: No operand bit outside a lane affects that lane's result.
- R9: When valid_i is low, result_o keeps its previous value.
- R10: The byte opcode with 8-bit lanes makes every result byte either 0x00 or 0xFF, taken from bit 0 of that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| operand_i | input | 64 | Packed source operand |
| ew_i | input | 2 | Lane width select |
| op_i | input | 2 | Opcode: byte, half, word, pass |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| result_o | output | 64 | Registered result |

## Verification
The assertions check four things on every cycle: the valid delay, the hold of result_o when no operation is issued, the exact pass-through copy, and the byte-mask shape of 8-bit byte results. They also check the 64-bit word extension at the port level. The bench's scenarios are the only check on the per-lane field widths for every lane width and opcode pair. They are also the only check on lane isolation, using patterns where a neighbouring lane carries a set sign bit. The bench's reference model computes the result bit by bit from the requirements, not from the design.

// File: rtl/elw_sext_pkg.sv
package elw_sext_pkg;
  typedef enum logic [1:0] {
    OP_BYTE = 2'b00,
    OP_HALF = 2'b01,
    OP_WORD = 2'b10,
    OP_PASS = 2'b11
  } sext_op_e;

  localparam int unsigned NUM_EW = 4;
  localparam int unsigned EW_W   = $clog2(NUM_EW);
endpackage

// File: rtl/elw_sext_lane.sv
module elw_sext_lane
  import elw_sext_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] lane_i,
  input  sext_op_e          op_i,
  output logic [LANE_W-1:0] lane_o
);
  localparam int unsigned SW_B = LANE_W / 8;
  localparam int unsigned SW_H = LANE_W / 4;
  localparam int unsigned SW_W = LANE_W / 2;

  always_comb begin
    unique case (op_i)
      OP_BYTE: lane_o = {{(LANE_W-SW_B){lane_i[SW_B-1]}}, lane_i[SW_B-1:0]};
      OP_HALF: lane_o = {{(LANE_W-SW_H){lane_i[SW_H-1]}}, lane_i[SW_H-1:0]};
      OP_WORD: lane_o = {{(LANE_W-SW_W){lane_i[SW_W-1]}}, lane_i[SW_W-1:0]};
      default: lane_o = lane_i;
    endcase
  end
endmodule

// File: rtl/elw_sext_slice.sv
module elw_sext_slice
  import elw_sext_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  sext_op_e          op_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned NUM_LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    elw_sext_lane #(.LANE_W(LANE_W)) i_lane (
      .lane_i (data_i[l*LANE_W +: LANE_W]),
      .op_i   (op_i),
      .lane_o (data_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/elw_sext_unit.sv
module elw_sext_unit
  import elw_sext_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [EW_W-1:0]   ew_i,
  input  logic [1:0]        op_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  sext_op_e          op;
  logic [DATA_W-1:0] slice_res [NUM_EW];
  logic [DATA_W-1:0] result_d;
  logic [DATA_W-1:0] result_q;
  logic              valid_q;

  assign op = sext_op_e'(op_i);

  // ew index g selects lane width DATA_W >> g
  for (genvar g = 0; g < NUM_EW; g++) begin : g_ew
    elw_sext_slice #(
      .DATA_W (DATA_W),
      .LANE_W (DATA_W >> g)
    ) i_slice (
      .data_i (operand_i),
      .op_i   (op),
      .data_o (slice_res[g])
    );
  end

  assign result_d = slice_res[ew_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) result_q <= result_d;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = result_q;
endmodule

// File: rtl/elw_sext_checker.sv
module elw_sext_checker #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [1:0]        ew_i,
  input logic [1:0]        op_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  function automatic bit bytes_are_masks(logic [DATA_W-1:0] v);
    for (int i = 0; i < DATA_W / 8; i++)
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) return 1'b0;
    return 1'b1;
  endfunction

  always_comb begin
    if (!rst_ni) assert_valid_low_in_reset_R1: assert (valid_o == 1'b0);
  end

  assert_valid_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_word64_ext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ew_i == 2'b00 && op_i == 2'b10) |=>
      (result_o[31:0] == $past(operand_i[31:0]) &&
       result_o[DATA_W-1:32] == {(DATA_W-32){$past(operand_i[31])}}));
  assert_pass_copy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b11) |=> result_o == $past(operand_i));
  assert_hold_result_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  assert_byte_masks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ew_i == 2'b11 && op_i == 2'b00) |=> bytes_are_masks(result_o));
endmodule

bind elw_sext_unit elw_sext_checker #(.DATA_W(DATA_W)) i_elw_sext_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .operand_i (operand_i),
  .ew_i      (ew_i),
  .op_i      (op_i),
  .valid_o   (valid_o),
  .result_o  (result_o)
);

// File: tb/test_elw_sext_unit.sv
module test_elw_sext_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic [1:0]  ew_i = '0;
  logic [1:0]  op_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [63:0] exp_q [$];
  string       tag_q [$];
  logic [63:0] last_exp = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  elw_sext_unit i_elw_sext_unit (
    .clk_i, .rst_ni, .valid_i, .operand_i, .ew_i, .op_i, .valid_o, .result_o
  );

  function automatic logic [63:0] ref_model(logic [63:0] v, logic [1:0] ew, logic [1:0] op);
    logic [63:0] r;
    int lw, sw;
    if (op == 2'b11) return v;
    lw = 64 >> ew;
    sw = lw >> (3 - op);
    for (int l = 0; l < 64 / lw; l++)
      for (int b = 0; b < lw; b++)
        r[l*lw + b] = (b < sw) ? v[l*lw + b] : v[l*lw + sw - 1];
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic [63:0] v, logic [1:0] ew, logic [1:0] op);
    @(negedge clk_i);
    operand_i = v; ew_i = ew; op_i = op; valid_i = 1'b1;
    last_exp = ref_model(v, ew, op);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      operand_i = 64'hDEAD_BEEF_F00D_CAFE; ew_i = 2'b01; op_i = 2'b10;
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2: actual valid_o 1 expected 0 (no pending item)");
      end else begin
        string t;
        logic [63:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, result_o, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", {63'd0, valid_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", {63'd0, valid_o}, 64'd0);

    // R10 / R3: byte op on 8-bit lanes -> masks
    drive("R10", 64'h0102_0301_FEFF_00A5, 2'b11, 2'b00);
    // R3 byte op across widths
    drive("R3", 64'h0000_0000_0000_0080, 2'b00, 2'b00);
    drive("R3", 64'h1234_8008_0070_0F0F, 2'b01, 2'b00);
    drive("R3", 64'hF002_0001_0003_0002, 2'b10, 2'b00);
    // R4 half: 32-bit lanes widen low byte
    drive("R4", 64'h1111_1180_2222_227F, 2'b01, 2'b01);
    drive("R4", 64'hAAAA_5555_0F0F_F0F0, 2'b11, 2'b01);
    drive("R4", 64'h0000_0000_0000_8000, 2'b00, 2'b01);
    drive("R4", 64'h0008_0007_FFF8_0080, 2'b10, 2'b01);
    // R5 word
    drive("R5", 64'h0123_4567_8000_0001, 2'b00, 2'b10);
    drive("R5", 64'h0000_8000_FFFF_7FFF, 2'b01, 2'b10);
    drive("R5", 64'h0080_007F_1234_ABCD, 2'b10, 2'b10);
    drive("R5", 64'h0809_7A6B_C5D4_E3F2, 2'b11, 2'b10);
    // R6 same operand, each width
    for (int e = 0; e < 4; e++) drive("R6", 64'h8888_8888_8888_8888, e[1:0], 2'b01);
    // R7 pass
    drive("R7", 64'hCAFE_F00D_1234_5678, 2'b11, 2'b11);
    drive("R7", 64'h8000_0000_0000_0001, 2'b00, 2'b11);
    // R8 isolation: neighbour lanes carry set bits, target lane clear
    drive("R8", 64'hFFFF_FFFF_0000_0000, 2'b01, 2'b00);
    drive("R8", 64'hFF00_FF00_FF00_FF00, 2'b11, 2'b01);
    drive("R8", 64'h0000_FFFF_0000_FFFF, 2'b10, 2'b00);
    idle(3);
    // R9: result held while valid_i is low
    check("R9", result_o, last_exp);
    check("R2", {63'd0, valid_o}, 64'd0);
    idle(2);
    check("R9", result_o, last_exp);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule